// File: doc/BRIEF.md
# Periodic Core Rotation Controller

This controller spreads single-threaded execution over a ring of identical fast cores so that the heat of one busy core never stays in one place for long. Exactly one core runs at a time. It runs for a programmed number of clock cycles, and then execution moves on to the next core in the ring. Every core that is not running has its clock stopped and its power switched off. The one exception is the successor, which is powered early so that its wake-up time is hidden behind the end of the current turn.

At the end of each turn the controller does three things in order. First, it asks the outgoing core to write its dirty L1 lines back to the shared last-level cache, and it waits for the acknowledgement. Second, it removes power and clock from that core, including its private caches. Third, it waits until the successor reports that it is ready, and only then names the successor as the active core. The turn length and the wake lead time are inputs. Both are sampled at the start of each turn, so they can be changed at runtime as the core count or the thermal budget changes.

Top module: `mig_core_rotator`

## Requirements
- R1: While reset is held, and after it is released, the controller selects core 0 and powers only core 0. It drives no clock enable and no flush request until core 0 reports ready. Once core 0 is ready, core 0 starts its first turn.
- R2: In every cycle outside reset, exactly one bit of `active_onehot` is high, and that bit is the one whose position equals `active_idx`.
- R3: When the active index changes from j, the new index is always (j+1) mod N_CORES.
- R4: A turn begins in the cycle in which the core's clock enable rises. Each turn then lasts exactly max(`cfg_interval`,1) cycles with the core's clock enabled and `flush_req` low. The value used is the one present at the start of that turn.
- R5: The successor's `pwr_on` bit rises exactly min(`cfg_lead`, max(`cfg_interval`,1)) cycles before the first cycle of `flush_req`. A lead of 0 means it rises in that same first cycle.
- R6: `flush_req` stays high until `flush_done` is sampled high. During the flush, the outgoing core keeps both its clock and its power.
- R7: In the cycle after `flush_done` is accepted, the outgoing core's `pwr_on` and `clk_en` are both low, and `flush_req` is low.
- R8: The active index moves to the successor only after a clock edge at which that successor's `core_ready` was high. The successor's `clk_en` is high in the same cycle in which it becomes active.
- R9: A `clk_en` bit is high only for the active core and only while that core is powered. At most two `pwr_on` bits are high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_interval | input | CNT_W | Turn length in cycles (0 is treated as 1) |
| cfg_lead | input | CNT_W | Wake lead time in cycles, clamped to the turn length |
| core_ready | input | N_CORES | Per-core indication that power-up has completed |
| flush_done | input | 1 | Acknowledgement that the outgoing L1 write-back has finished |
| pwr_on | output | N_CORES | Per-core power enable |
| clk_en | output | N_CORES | Per-core clock enable |
| flush_req | output | 1 | Request to write back the active core's dirty L1 lines |
| active_idx | output | IDX_W | Index of the current core |
| active_onehot | output | N_CORES | One-hot select of the current core |

## Verification
Two functions can fall into the same cycle. The early wake of the successor can coincide with the start of the turn, or with the start of the flush. This happens when the lead equals the clamped interval (including a zero interval, and a lead larger than the interval), and when the lead is zero. The bench forces these cases in directed turns and also reaches them by random settings. For each turn it measures the distance between the rise of the successor's power bit and the first flush cycle. A second overlap is a successor that is already ready when the flush completes, versus one that wakes after the flush. Long and short random wake latencies provoke both, and each handoff is judged against the ready value the bench drove before the switching edge.

// File: rtl/mig_pkg.sv
package mig_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RUN     = 3'd1,
        ST_PREWAKE = 3'd2,
        ST_FLUSH   = 3'd3,
        ST_HANDOFF = 3'd4
    } mig_state_e;

endpackage

// File: rtl/mig_interval_timer.sv
module mig_interval_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [CNT_W-1:0] cfg_interval,
    input  logic [CNT_W-1:0] cfg_lead,
    output logic             wake_now,
    output logic             wake_hit,
    output logic             end_hit
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] end_at;
        logic [CNT_W-1:0] wake_at;
        logic             wake_en;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [CNT_W-1:0] int_eff;
    logic [CNT_W-1:0] lead_eff;

    // effective interval and clamped lead from the live configuration
    always_comb begin
        int_eff  = (cfg_interval == '0) ? CNT_W'(1) : cfg_interval;
        lead_eff = (cfg_lead > int_eff) ? int_eff : cfg_lead;
        wake_now = (lead_eff == int_eff);
    end

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.cnt     = '0;
            tmr_d.end_at  = int_eff - CNT_W'(1);
            tmr_d.wake_en = (lead_eff != '0) && (lead_eff != int_eff);
            tmr_d.wake_at = int_eff - lead_eff - CNT_W'(1);
        end else if (run) begin
            tmr_d.cnt = tmr_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign end_hit  = run && (tmr_q.cnt == tmr_q.end_at);
    assign wake_hit = run && tmr_q.wake_en && (tmr_q.cnt == tmr_q.wake_at);

endmodule

// File: rtl/mig_ring_select.sv
module mig_ring_select #(
    parameter int N_CORES = 4,
    parameter int IDX_W   = 2
) (
    input  logic [IDX_W-1:0]   active_idx,
    input  logic               keep_cur_pwr,
    input  logic               wake_next,
    input  logic               cur_clk,
    output logic [IDX_W-1:0]   next_idx,
    output logic [N_CORES-1:0] pwr_on,
    output logic [N_CORES-1:0] clk_en,
    output logic [N_CORES-1:0] active_onehot
);

    assign next_idx = (active_idx == IDX_W'(N_CORES - 1)) ? '0
                                                          : active_idx + IDX_W'(1);

    for (genvar i = 0; i < N_CORES; i++) begin : g_core
        logic is_cur;
        logic is_nxt;
        assign is_cur           = (active_idx == IDX_W'(i));
        assign is_nxt           = (next_idx == IDX_W'(i));
        assign active_onehot[i] = is_cur;
        assign pwr_on[i]        = (is_cur && keep_cur_pwr) || (is_nxt && wake_next);
        assign clk_en[i]        = is_cur && cur_clk;
    end

endmodule

// File: rtl/mig_core_rotator.sv
module mig_core_rotator
    import mig_pkg::*;
#(
    parameter int N_CORES = 4,
    parameter int CNT_W   = 24,
    localparam int IDX_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   cfg_interval,
    input  logic [CNT_W-1:0]   cfg_lead,
    input  logic [N_CORES-1:0] core_ready,
    input  logic               flush_done,
    output logic [N_CORES-1:0] pwr_on,
    output logic [N_CORES-1:0] clk_en,
    output logic               flush_req,
    output logic [IDX_W-1:0]   active_idx,
    output logic [N_CORES-1:0] active_onehot
);

    typedef struct packed {
        mig_state_e       st;
        logic [IDX_W-1:0] idx;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic             tmr_load;
    logic             tmr_run;
    logic             wake_now;
    logic             wake_hit;
    logic             end_hit;
    logic [IDX_W-1:0] next_idx;
    logic             keep_cur_pwr;
    logic             wake_next;
    logic             cur_clk;

    mig_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (tmr_load),
        .run          (tmr_run),
        .cfg_interval (cfg_interval),
        .cfg_lead     (cfg_lead),
        .wake_now     (wake_now),
        .wake_hit     (wake_hit),
        .end_hit      (end_hit)
    );

    mig_ring_select #(.N_CORES(N_CORES), .IDX_W(IDX_W)) u_ring (
        .active_idx    (ctl_q.idx),
        .keep_cur_pwr  (keep_cur_pwr),
        .wake_next     (wake_next),
        .cur_clk       (cur_clk),
        .next_idx      (next_idx),
        .pwr_on        (pwr_on),
        .clk_en        (clk_en),
        .active_onehot (active_onehot)
    );

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (core_ready[ctl_q.idx]) begin
                    tmr_load = 1'b1;
                    ctl_d.st = wake_now ? ST_PREWAKE : ST_RUN;
                end
            end
            ST_RUN: begin
                if (end_hit) begin
                    ctl_d.st = ST_FLUSH;
                end else if (wake_hit) begin
                    ctl_d.st = ST_PREWAKE;
                end
            end
            ST_PREWAKE: begin
                if (end_hit) begin
                    ctl_d.st = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                if (flush_done) begin
                    ctl_d.st = ST_HANDOFF;
                end
            end
            ST_HANDOFF: begin
                if (core_ready[next_idx]) begin
                    tmr_load  = 1'b1;
                    ctl_d.idx = next_idx;
                    ctl_d.st  = wake_now ? ST_PREWAKE : ST_RUN;
                end
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st  <= ST_IDLE;
            ctl_q.idx <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign tmr_run      = (ctl_q.st == ST_RUN) || (ctl_q.st == ST_PREWAKE);
    assign keep_cur_pwr = (ctl_q.st != ST_HANDOFF);
    assign wake_next    = (ctl_q.st == ST_PREWAKE) || (ctl_q.st == ST_FLUSH)
                       || (ctl_q.st == ST_HANDOFF);
    assign cur_clk      = tmr_run || (ctl_q.st == ST_FLUSH);
    assign flush_req    = (ctl_q.st == ST_FLUSH);
    assign active_idx   = ctl_q.idx;

endmodule

// File: rtl/mig_rotation_checker.sv
module mig_rotation_checker #(
    parameter int N_CORES = 4,
    parameter int IDX_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_CORES-1:0] core_ready,
    input logic               flush_done,
    input logic [N_CORES-1:0] pwr_on,
    input logic [N_CORES-1:0] clk_en,
    input logic               flush_req,
    input logic [IDX_W-1:0]   active_idx,
    input logic [N_CORES-1:0] active_onehot
);

    logic [N_CORES-1:0] rdy_q;
    logic [IDX_W-1:0]   idx_q;
    logic [IDX_W-1:0]   succ_of_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_q <= '0;
            idx_q <= '0;
        end else begin
            rdy_q <= core_ready;
            idx_q <= active_idx;
        end
    end

    always_comb begin
        succ_of_q = (idx_q == IDX_W'(N_CORES - 1)) ? '0 : idx_q + IDX_W'(1);
    end

    AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(active_onehot)); // R2

    AST_RING_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (active_idx != idx_q) |-> (active_idx == succ_of_q)); // R3

    AST_FLUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_done) |=> flush_req); // R6

    AST_OFF_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && flush_done) |=> ((pwr_on & active_onehot) == '0) && (clk_en == '0)); // R7

    AST_SWITCH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (active_idx != idx_q) |-> rdy_q[active_idx]); // R8

    AST_CLK_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en & ~(active_onehot & pwr_on)) == '0); // R9

    AST_PWR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pwr_on) <= 2); // R9

endmodule

bind mig_core_rotator mig_rotation_checker #(
    .N_CORES (N_CORES),
    .IDX_W   (IDX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .core_ready    (core_ready),
    .flush_done    (flush_done),
    .pwr_on        (pwr_on),
    .clk_en        (clk_en),
    .flush_req     (flush_req),
    .active_idx    (active_idx),
    .active_onehot (active_onehot)
);

// File: tb/mig_core_rotator_tb.sv
`timescale 1ns/1ps
module mig_core_rotator_tb;

    localparam int N  = 4;
    localparam int CW = 24;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cfg_interval;
    logic [CW-1:0] cfg_lead;
    logic [N-1:0]  core_ready;
    logic          flush_done;
    logic [N-1:0]  pwr_on;
    logic [N-1:0]  clk_en;
    logic          flush_req;
    logic [IW-1:0] active_idx;
    logic [N-1:0]  active_onehot;

    always #2 clk = ~clk;

    mig_core_rotator #(.N_CORES(N), .CNT_W(CW)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_interval  (cfg_interval),
        .cfg_lead      (cfg_lead),
        .core_ready    (core_ready),
        .flush_done    (flush_done),
        .pwr_on        (pwr_on),
        .clk_en        (clk_en),
        .flush_req     (flush_req),
        .active_idx    (active_idx),
        .active_onehot (active_onehot)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int swaps  = 0;
    bit mon_on = 1'b0;
    bit done   = 1'b0;

    int exp_int, exp_lead;
    int wake_lat, flush_lat, cur_flush_lat;
    int run_len, wake_cyc, flush_len, prev_idx;
    int pc [N];
    logic [N-1:0] pwr_prev, rdy_prev;
    logic prev_flush, prev_done;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int eff_int(input int iv);
        return (iv == 0) ? 1 : iv;
    endfunction

    function automatic int eff_lead(input int ld, input int iv);
        int e;
        e = eff_int(iv);
        return (ld > e) ? e : ld;
    endfunction

    // choose settings for the next turn: directed corners first, then random
    task automatic pick_cfg(input int m);
        int iv, ld;
        case (m)
            0: begin iv = 0;  ld = 5;  wake_lat = 2;  flush_lat = 1; end // interval 0
            1: begin iv = 6;  ld = 20; wake_lat = 3;  flush_lat = 3; end // lead clamp
            2: begin iv = 8;  ld = 0;  wake_lat = 4;  flush_lat = 2; end // lead 0
            3: begin iv = 5;  ld = 5;  wake_lat = 1;  flush_lat = 1; end // lead = interval
            4: begin iv = 7;  ld = 1;  wake_lat = 12; flush_lat = 1; end // slow wake
            5: begin iv = 1;  ld = 1;  wake_lat = 1;  flush_lat = 4; end
            default: begin
                iv = ($urandom % 8 == 0) ? 0 : 1 + int'($urandom % 30);
                ld = int'($urandom % 36);
                wake_lat  = 1 + int'($urandom % 10);
                flush_lat = 1 + int'($urandom % 6);
            end
        endcase
        cfg_interval = CW'(iv);
        cfg_lead     = CW'(ld);
        exp_int  = eff_int(iv);
        exp_lead = eff_lead(ld, iv);
    endtask

    always @(negedge clk) begin
        if (mon_on && !done) begin
            int nx;
            cyc++;
            // R2 / R9 every cycle
            chk($onehot(active_onehot) && active_onehot[active_idx], "R2",
                "onehot", int'(active_onehot), 1 << active_idx);
            chk((clk_en & ~(active_onehot & pwr_on)) == '0, "R9", "clk_en",
                int'(clk_en), int'(clk_en & active_onehot & pwr_on));
            chk($countones(pwr_on) <= 2, "R9", "pwr count", $countones(pwr_on), 2);
            nx = (int'(active_idx) + 1) % N;
            if (pwr_on[nx] && !pwr_prev[nx]) wake_cyc = cyc;
            if (clk_en != '0 && !flush_req) run_len++;
            if (flush_req && !prev_flush) begin
                chk(run_len == exp_int, "R4", "turn length", run_len, exp_int);
                chk(cyc - wake_cyc == exp_lead, "R5", "wake lead", cyc - wake_cyc, exp_lead);
                run_len   = 0;
                flush_len = 0;
                cur_flush_lat = flush_lat;
                pick_cfg(swaps);
            end
            if (flush_req) begin
                flush_len++;
                chk(clk_en[active_idx] && pwr_on[active_idx], "R6", "flush keeps core",
                    int'({clk_en[active_idx], pwr_on[active_idx]}), 3);
            end
            if (prev_done) begin
                chk(!pwr_on[active_idx] && clk_en == '0 && !flush_req, "R7", "off after flush",
                    int'({pwr_on[active_idx], |clk_en, flush_req}), 0);
                chk(flush_len == cur_flush_lat, "R6", "flush length", flush_len, cur_flush_lat);
            end
            if (int'(active_idx) != prev_idx) begin
                chk(int'(active_idx) == (prev_idx + 1) % N, "R3", "ring step",
                    int'(active_idx), (prev_idx + 1) % N);
                chk(rdy_prev[active_idx] && clk_en[active_idx], "R8", "ready switch",
                    int'({rdy_prev[active_idx], clk_en[active_idx]}), 3);
                swaps++;
            end
            prev_idx   = int'(active_idx);
            prev_flush = flush_req;
            pwr_prev   = pwr_on;
            // environment models
            prev_done  = flush_req && (flush_len == cur_flush_lat);
            flush_done = prev_done;
            rdy_prev   = core_ready;
            for (int i = 0; i < N; i++) begin
                if (pwr_on[i]) pc[i]++; else pc[i] = 0;
                core_ready[i] = pwr_on[i] && (pc[i] >= wake_lat);
            end
            rdy_prev = core_ready;
            if (cyc > 50000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected=0", cyc);
                done = 1'b1;
            end
            if (swaps >= 60) done = 1'b1;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        core_ready = '0;
        flush_done = 1'b0;
        cfg_interval = CW'(10);
        cfg_lead     = CW'(3);
        exp_int = 10; exp_lead = 3;
        wake_lat = 4; flush_lat = 2; cur_flush_lat = 2;
        run_len = 0; wake_cyc = 0; flush_len = 0; prev_idx = 0;
        pwr_prev = '0; rdy_prev = '0; prev_flush = 1'b0; prev_done = 1'b0;
        for (int i = 0; i < N; i++) pc[i] = 0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(active_idx == '0 && active_onehot == 4'b0001, "R1", "reset select",
            int'(active_onehot), 1);
        chk(pwr_on == 4'b0001 && clk_en == '0 && !flush_req, "R1", "reset power",
            int'({pwr_on, clk_en, flush_req}), 9'b0001_0000_0 );
        rst_n = 1'b1;
        pwr_prev = pwr_on;
        @(negedge clk);
        chk(clk_en == '0 && pwr_on == 4'b0001 && !flush_req, "R1", "waits for ready",
            int'(clk_en), 0);
        pc[0] = 1;
        core_ready[0] = (pc[0] >= wake_lat);
        mon_on = 1'b1;
        wait (done);
        @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule